// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block guards against software that has lost control. A prescaler divides the CPU clock by one of two ratios, and each prescaler output tick steps a down counter. Software must keep reloading the counter with refresh writes. If the counter runs out, the block reports the timeout. It reports it either as an interrupt request or as a request to reset the system. Software chooses which, and once it has chosen reset it cannot go back.

A fixed configuration input decides whether the watchdog runs from the moment reset ends or waits idle for a start write. A low-power hold input freezes both the prescaler and the counter, and counting resumes from the held values when the hold is released. The counter value can be read at all times. Bus decode, option storage and the reset sequencer lie outside the block. The reset request is a one-cycle pulse, and the surrounding system feeds it back into the block's reset.

Top module: `wdt_core`

## Requirements
- R1: During and directly after reset, `count_o` holds all ones (0x7FFF at the default width of 15 bits), `irq_o` and `rst_req_o` are low, and the timeout action is interrupt.
- R2: While counting, the counter steps down by one every 16 clocks when `div_sel_i` is 0 and every 128 clocks when `div_sel_i` is 1.
- R3: The counter steps from all ones down to zero. The next tick after zero is the underflow, so a timeout takes prescale × 2^CNT_W clocks. At the underflow the counter reloads all ones and keeps counting.
- R4: An underflow produces one cycle of `irq_o` when the action bit is 0, and one cycle of `rst_req_o` when it is 1. It never produces both, and the pulse appears in the cycle after the underflowing edge.
- R5: A mode write with data 1 sets the action bit to reset. A mode write with data 0 has no effect. Only a reset of the block returns the bit to interrupt. An underflow on the same edge as a mode write acts on the old value.
- R6: An accepted refresh loads all ones on the next edge, and counting continues from there. A refresh does not clear the prescaler phase, so the first step after it can come in fewer than a full prescale period.
- R7: A refresh on the same edge as an underflow wins. The counter holds all ones and no pulse is produced.
- R8: With `autostart_off_i` at 0, the prescaler and counter run from the first edge after reset.
- R9: With `autostart_off_i` at 1, the block stays idle after reset, with the counter at all ones and no pulses, until a start write. Refresh writes made before the start are ignored. Counting begins on the edge after the start write.
- R10: Once the block runs, further start writes do not change the count sequence.
- R11: While `sleep_i` is high, the prescaler and counter hold their values and no pulse is produced. Counting resumes from the held values when `sleep_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| refresh_i | input | 1 | Refresh write strobe; reloads the counter |
| start_i | input | 1 | Start write strobe |
| div_sel_i | input | 1 | Prescale select: 0 gives divide by 16, 1 gives divide by 128 |
| mode_we_i | input | 1 | Write strobe for the timeout action bit |
| mode_wd_i | input | 1 | Action bit write data: 1 selects reset |
| autostart_off_i | input | 1 | Fixed option: 0 runs after reset, 1 waits for a start write |
| sleep_i | input | 1 | Low-power hold: freezes the prescaler and counter |
| irq_o | output | 1 | One-cycle timeout interrupt request |
| rst_req_o | output | 1 | One-cycle timeout reset request |
| count_o | output | CNT_W | Current counter value |

## Verification
The case that needs the most care is a refresh arriving on the very edge where the counter would underflow. A timeout pulse and a reload then compete in the same cycle. The bench provokes this by predicting, from elapsed cycles and the prescale ratio, the edge on which the underflow tick falls, and strobing refresh exactly there. It then expects all ones on the counter and no pulse. Sleep is held across a pending underflow in the same way, and the pulse must then appear only on the first edge after the hold is released. A mode write is also placed on the underflowing edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Action taken when the counter runs out
  typedef enum logic {
    ACT_IRQ   = 1'b0,
    ACT_RESET = 1'b1
  } wdt_action_e;
endpackage

// File: rtl/wdt_presc.sv
module wdt_presc #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sel_i,
  output logic tick_o
);
  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] LO_M1 = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] HI_M1 = PW'(DIV_HI - 1);

  logic [PW-1:0] pre_q, pre_d, lim;
  logic          wrap;

  always_comb begin
    lim    = sel_i ? HI_M1 : LO_M1;
    wrap   = (pre_q >= lim);
    tick_o = en_i & wrap;
    pre_d  = pre_q;
    if (en_i) begin
      pre_d = wrap ? '0 : pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_down.sv
module wdt_down #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    uf_o  = tick_i & ~load_i & (cnt_q == '0);
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = FULL;
    end else if (tick_i) begin
      cnt_d = (cnt_q == '0) ? FULL : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FULL;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we_i,
  input  logic        mode_wd_i,
  input  logic        uf_i,
  output logic        irq_o,
  output logic        rst_req_o,
  output wdt_action_e mode_o
);
  wdt_action_e mode_q, mode_d;
  logic        irq_q, irq_d, rr_q, rr_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we_i && mode_wd_i) mode_d = ACT_RESET;
    irq_d = uf_i & (mode_q == ACT_IRQ);
    rr_d  = uf_i & (mode_q == ACT_RESET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ACT_IRQ;
      irq_q  <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      irq_q  <= irq_d;
      rr_q   <= rr_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rr_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_i,
  input  logic             start_i,
  input  logic             div_sel_i,
  input  logic             mode_we_i,
  input  logic             mode_wd_i,
  input  logic             autostart_off_i,
  input  logic             sleep_i,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] count_o
);
  logic        started_q, started_d;
  logic        active, run_en, load, tick, uf;
  wdt_action_e mode;

  always_comb begin
    started_d = started_q | start_i;
    active    = ~autostart_off_i | started_q;
    run_en    = active & ~sleep_i;
    load      = refresh_i & active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= started_d;
  end

  wdt_presc #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(run_en), .sel_i(div_sel_i), .tick_o(tick)
  );

  wdt_down #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
    .cnt_o(count_o), .uf_o(uf)
  );

  wdt_resp u_resp (
    .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we_i), .mode_wd_i(mode_wd_i),
    .uf_i(uf), .irq_o(irq_o), .rst_req_o(rst_req_o), .mode_o(mode)
  );
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh_i,
  input logic             sleep_i,
  input logic             active_i,
  input wdt_action_e      mode_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o)); // R4

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R4

  AST_RSTREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> (count_o == FULL) || (count_o == $past(count_o) - CNT_W'(1))); // R3

  AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_i && active_i) |=> (count_o == FULL) && !irq_o && !rst_req_o); // R6

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !refresh_i) |=> $stable(count_o) && !irq_o && !rst_req_o); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (count_o == FULL) && !irq_o && !rst_req_o); // R9

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == ACT_RESET) |=> (mode_i == ACT_RESET)); // R5
endmodule

bind wdt_core wdt_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_i(refresh_i), .sleep_i(sleep_i),
  .active_i(active), .mode_i(mode), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .count_o(count_o)
);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk, rst_n;
  logic refresh_i, start_i, div_sel_i, mode_we_i, mode_wd_i, autostart_off_i, sleep_i;
  logic irq_o, rst_req_o;
  logic [W-1:0] count_o;

  wdt_core #(.CNT_W(W), .DIV_LO(16), .DIV_HI(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .refresh_i(refresh_i), .start_i(start_i),
    .div_sel_i(div_sel_i), .mode_we_i(mode_we_i), .mode_wd_i(mode_wd_i),
    .autostart_off_i(autostart_off_i), .sleep_i(sleep_i),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .count_o(count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int  n_chk = 0, n_fail = 0, n_cyc = 0;
  bit  done = 0;
  int  m_j, m_load, m_div, n_irq, n_rr;
  bit  m_act, m_mode, last_uf;

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", n_cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit off);
    @(negedge clk);
    autostart_off_i = off; div_sel_i = 0;
    refresh_i = 0; start_i = 0; mode_we_i = 0; mode_wd_i = 0; sleep_i = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(count_o == W'(M), "R1 count in reset", int'(count_o), M);
    chk(irq_o == 0 && rst_req_o == 0, "R1 outputs in reset", int'({irq_o, rst_req_o}), 0);
    rst_n = 1;
    m_j = 0; m_load = 0; m_div = 16; m_mode = 0; m_act = !off;
  endtask

  // One clock: drive strobes for the coming edge, then check the result.
  task automatic cyc(input bit rf, input bit sl, input bit st, input bit mw, input bit mv,
                     input string tag);
    bit uf, old_mode;
    int k;
    refresh_i = rf; sleep_i = sl; start_i = st; mode_we_i = mw; mode_wd_i = mv;
    @(negedge clk);
    refresh_i = 0; sleep_i = 0; start_i = 0; mode_we_i = 0; mode_wd_i = 0;
    old_mode = m_mode;
    if (mw && mv) m_mode = 1;
    uf = 0; k = 0;
    if (!m_act) begin
      if (st) m_act = 1;
    end else begin
      if (!sl) m_j++;
      if (rf) m_load = m_j;
      k = m_j / m_div - m_load / m_div;
      if (k == M + 1) begin
        uf = 1; m_j = 0; m_load = 0; k = 0;
      end
    end
    chk(count_o == W'(M - k), {tag, " count"}, int'(count_o), M - k);
    chk(irq_o == (uf && !old_mode), {tag, " irq"}, int'(irq_o), int'(uf && !old_mode));
    chk(rst_req_o == (uf && old_mode), {tag, " rst_req"}, int'(rst_req_o), int'(uf && old_mode));
    if (irq_o) n_irq++;
    if (rst_req_o) n_rr++;
    last_uf = uf;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic run_to_uf(input string tag);
    for (int i = 0; i < 5000; i++) begin
      cyc(0, 0, 0, 0, 0, tag);
      if (last_uf) break;
    end
  endtask

  function automatic bit next_is_uf();
    return ((m_j + 1) % m_div == 0) && ((m_j + 1) / m_div - m_load / m_div == M + 1);
  endfunction

  initial begin
    rst_n = 0;
    refresh_i = 0; start_i = 0; div_sel_i = 0; mode_we_i = 0; mode_wd_i = 0;
    autostart_off_i = 0; sleep_i = 0;

    // R8 R2 R3: free run from reset at divide by 16
    do_reset(0);
    n_irq = 0;
    run(600, "R8 R2 R3 run");
    chk(n_irq == 600 / (16 * (M + 1)), "R3 timeout count", n_irq, 600 / (16 * (M + 1)));

    // R6: refresh at every prescaler phase
    for (int p = 0; p < 16; p++) begin
      run(20 + p, "R6 gap");
      for (int i = 0; i < 16; i++) begin
        if (m_j % m_div == p) break;
        cyc(0, 0, 0, 0, 0, "R6 align");
      end
      cyc(1, 0, 0, 0, 0, "R6 refresh");
      chk(count_o == W'(M), "R6 reload", int'(count_o), M);
    end

    // R7: refresh on the underflowing edge
    for (int i = 0; i < 5000; i++) begin
      if (next_is_uf()) break;
      cyc(0, 0, 0, 0, 0, "R7 approach");
    end
    cyc(1, 0, 0, 0, 0, "R7 collide");
    chk(irq_o == 0 && count_o == W'(M), "R7 refresh wins", int'({irq_o, count_o}), M);
    run(300, "R7 after");

    // R11: sleep bursts, one with a refresh inside
    for (int b = 0; b < 12; b++) begin
      run(23 + b, "R11 awake");
      for (int s = 0; s < 7; s++) cyc(b == 5 && s == 3, 1, 0, 0, 0, "R11 asleep");
    end
    // R11: sleep held over a pending underflow
    for (int i = 0; i < 5000; i++) begin
      if (next_is_uf()) break;
      cyc(0, 0, 0, 0, 0, "R11 approach");
    end
    n_irq = 0;
    for (int s = 0; s < 9; s++) cyc(0, 1, 0, 0, 0, "R11 held");
    chk(n_irq == 0, "R11 no pulse while held", n_irq, 0);
    cyc(0, 0, 0, 0, 0, "R11 resume");
    chk(last_uf == 1 && irq_o == 1, "R11 pulse after release", int'(irq_o), 1);

    // R2: divide by 128, switched at a phase-zero point
    div_sel_i = 1; m_div = 128;
    n_irq = 0;
    run(2 * 128 * (M + 1) + 5, "R2 div128");
    chk(n_irq == 2, "R2 div128 timeouts", n_irq, 2);
    run_to_uf("R2 realign");
    div_sel_i = 0; m_div = 16;
    run(100, "R2 back to div16");

    // R4 R5: select reset action, try to clear it
    cyc(0, 0, 0, 1, 1, "R5 set reset mode");
    n_rr = 0; n_irq = 0;
    run_to_uf("R4 reset action");
    chk(n_rr == 1 && n_irq == 0, "R4 reset pulse only", n_rr, 1);
    cyc(0, 0, 0, 1, 0, "R5 clear attempt");
    run_to_uf("R5 still reset");
    chk(n_rr == 2 && n_irq == 0, "R5 write 0 ignored", n_rr, 2);
    // system resets the block on the request
    do_reset(0);
    n_irq = 0; n_rr = 0;
    // R5: mode write on the underflowing edge acts on the old value
    for (int i = 0; i < 5000; i++) begin
      if (next_is_uf()) break;
      cyc(0, 0, 0, 0, 0, "R5 approach");
    end
    cyc(0, 0, 0, 1, 1, "R5 write at uf");
    chk(n_irq == 1 && n_rr == 0, "R5 reset returned to irq", n_irq, 1);
    run_to_uf("R5 new mode");
    chk(n_rr == 1, "R5 mode applies next", n_rr, 1);

    // R9 R10: start-on-write option
    do_reset(1);
    n_irq = 0;
    for (int i = 0; i < 400; i++) cyc(i % 50 == 7, 0, 0, 0, 0, "R9 idle");
    chk(n_irq == 0 && count_o == W'(M), "R9 stayed idle", int'(count_o), M);
    cyc(0, 0, 1, 0, 0, "R9 start");
    run(100, "R9 running");
    chk(count_o == W'(M - 100 / 16), "R9 counting after start", int'(count_o), M - 100 / 16);
    cyc(0, 0, 1, 0, 0, "R10 second start");
    cyc(0, 0, 1, 0, 0, "R10 third start");
    run(400, "R10 after");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule